// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a dual-channel, 12-bit, double-buffered DAC with a parallel bus. It takes one command at a time from a request interface and turns it into a sequence on the DAC bus that meets the bus timing rules. The DAC bus signals are chip select, channel select, data, one load strobe for each channel, clear, and the preset-level pin. The command can write a code into one channel's input register, transfer input registers to the outputs, clear the DAC with a chosen preset level, or run a dual update. A dual update writes both input registers and then fires both load strobes on the same cycle, so both analog outputs change together.

Every minimum time on the bus is a nanosecond parameter. Each one becomes a cycle count by ceiling division by the clock-period parameter, with a floor of one cycle. After a load or a clear, the block can add an optional wait for the analog output to settle. The length of this wait is a cycle count given with the command. Full settling can take up to 16 µs, which is 1600 cycles at 10 ns. The `busy` output stays high while a command runs, and `done` goes high for one cycle when the command ends.

Top module: `dacbus_seq`

## Requirements
- R1: After synchronous reset, `dac_cs_n`, `dac_load_a_n`, `dac_load_b_n` and `dac_clr_n` are high, `dac_half`, `dac_data`, `busy` and `done` are 0.
- R2: A write (`req_op`=0) drives `dac_cs_n` low for max(cs-width, channel-setup, data-setup) cycles starting on the cycle after acceptance. `dac_chan` and `dac_data` carry the requested channel (0=A, 1=B) and code from the first low cycle. They stay unchanged for the hold-time cycles after `dac_cs_n` rises.
- R3: A load (`req_op`=1) leaves all strobes high for the load-setup cycles, then holds low the strobe of each channel selected in `req_mask` (bit 0=A, bit 1=B) for the load-width cycles, then waits the load-hold cycles. A mask of 0 pulses no strobe but still runs the full sequence.
- R4: A dual update (`req_op`=3) writes `req_data` to channel A and then `req_data_b` to channel B, each as in R2, then performs a load of both channels as in R3. Both strobes fall on the same cycle and rise on the same cycle.
- R5: A clear (`req_op`=2) drives `dac_half` to `req_preset` one cycle before `dac_clr_n` falls. `dac_clr_n` then stays low for the reset-width cycles. `dac_half` keeps its value after the command ends.
- R6: When `settle_en` is 1 and `settle_cycles` N is nonzero, a load, clear or dual update ends N cycles later than it would otherwise. A write is never delayed, and N=0 or `settle_en`=0 adds no delay.
- R7: A request is accepted only in idle. `busy` is high from the cycle after acceptance until `done`, `done` is high for exactly one cycle with `busy` low, and a request made while busy has no effect on the bus.
- R8: While idle all strobes are high, and `dac_cs_n` is never low in the same cycle as a load strobe or `dac_clr_n`.
- R9: Each timing in cycles is ceil(ns / CLK_NS) with a minimum of 1. With a 10 ns clock this gives cs 3, hold 1, load setup 2, load width 2, load hold 1 and clear 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request, taken when idle |
| req_op | input | 2 | 0 write, 1 load, 2 clear, 3 dual update |
| req_chan | input | 1 | Write target channel, 0=A, 1=B |
| req_data | input | DATA_W | Write code (channel A code for dual update) |
| req_data_b | input | DATA_W | Channel B code for dual update |
| req_mask | input | 2 | Load channel select, bit 0=A, bit 1=B |
| req_preset | input | 1 | Clear level, 1 = half scale |
| settle_en | input | 1 | Enable post-update settling wait |
| settle_cycles | input | SETTLE_W | Settling wait length in cycles |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_chan | output | 1 | DAC channel select |
| dac_data | output | DATA_W | DAC data bus |
| dac_load_a_n | output | 1 | Channel A load strobe, active low |
| dac_load_b_n | output | 1 | Channel B load strobe, active low |
| dac_clr_n | output | 1 | DAC clear, active low |
| dac_half | output | 1 | DAC preset level pin |

## Verification
The bench writes distinct codes to each channel. It checks that the code and channel select on the bus match the request, which catches swapped channels and data changing too early. Loads are run with each of the four mask values, so a strobe on the wrong channel, a missing strobe, or a mask-0 command that skips the sequence all show up. The dual update uses different codes for A and B and checks where each strobe falls relative to the two writes. Clears with both preset values, settling waits that are on, zero or disabled, and a request injected mid-command pin down the preset, delay and ignore rules.

// File: rtl/dacseq_pkg.sv
`timescale 1ns/1ps
package dacseq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_LOAD  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_DUAL  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_WR_CS,
    PH_WR_HOLD,
    PH_LD_GAP,
    PH_LD_LOW,
    PH_LD_HOLD,
    PH_CL_PRE,
    PH_CL_LOW,
    PH_SETTLE
  } phase_e;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dacseq_timer.sv
`timescale 1ns/1ps
module dacseq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dacseq_ctrl.sv
`timescale 1ns/1ps
module dacseq_ctrl
  import dacseq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 16,
  parameter int TMR_W    = 16,
  parameter int CS_CYC   = 3,
  parameter int DH_CYC   = 1,
  parameter int LS_CYC   = 2,
  parameter int LDW_CYC  = 2,
  parameter int LH_CYC   = 1,
  parameter int CLW_CYC  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  op_e                 req_op,
  input  logic                req_chan,
  input  logic [DATA_W-1:0]   req_data,
  input  logic [DATA_W-1:0]   req_data_b,
  input  logic [1:0]          req_mask,
  input  logic                req_preset,
  input  logic                settle_en,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                tmr_expired,
  output logic                tmr_load,
  output logic [TMR_W-1:0]    tmr_val,
  output phase_e              phase_n,
  output logic                wr_load,
  output logic                wr_chan,
  output logic [DATA_W-1:0]   wr_data,
  output logic [1:0]          mask_q,
  output logic                half_load,
  output logic                half_val,
  output logic                busy,
  output logic                done
);
  phase_e              phase_q;
  op_e                 op_q;
  logic                second_q, second_n;
  logic                chan_q;
  logic [DATA_W-1:0]   code_a_q, code_b_q;
  logic                settle_q;
  logic [SETTLE_W-1:0] settle_len_q;
  logic                accept, finish;

  // phase sequencing
  always_comb begin
    phase_n   = phase_q;
    second_n  = second_q;
    accept    = 1'b0;
    finish    = 1'b0;
    wr_load   = 1'b0;
    wr_chan   = chan_q;
    wr_data   = code_a_q;
    half_load = 1'b0;
    half_val  = req_preset;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          unique case (req_op)
            OP_WRITE: begin
              phase_n = PH_WR_CS;
              wr_load = 1'b1;
              wr_chan = req_chan;
              wr_data = req_data;
            end
            OP_DUAL: begin
              phase_n  = PH_WR_CS;
              wr_load  = 1'b1;
              wr_chan  = 1'b0;
              wr_data  = req_data;
              second_n = 1'b0;
            end
            OP_LOAD:  phase_n = PH_LD_GAP;
            OP_CLEAR: begin
              phase_n   = PH_CL_PRE;
              half_load = 1'b1;
            end
            default: phase_n = PH_IDLE;
          endcase
        end
      end
      PH_WR_CS: if (tmr_expired) phase_n = PH_WR_HOLD;
      PH_WR_HOLD: begin
        if (tmr_expired) begin
          if (op_q == OP_DUAL && !second_q) begin
            phase_n  = PH_WR_CS;
            wr_load  = 1'b1;
            wr_chan  = 1'b1;
            wr_data  = code_b_q;
            second_n = 1'b1;
          end else if (op_q == OP_DUAL) begin
            phase_n = PH_LD_GAP;
          end else begin
            finish  = 1'b1;
            phase_n = PH_IDLE;
          end
        end
      end
      PH_LD_GAP: if (tmr_expired) phase_n = PH_LD_LOW;
      PH_LD_LOW: if (tmr_expired) phase_n = PH_LD_HOLD;
      PH_LD_HOLD, PH_CL_LOW: begin
        if (tmr_expired) begin
          if (settle_q) phase_n = PH_SETTLE;
          else begin
            finish  = 1'b1;
            phase_n = PH_IDLE;
          end
        end
      end
      PH_CL_PRE: if (tmr_expired) phase_n = PH_CL_LOW;
      PH_SETTLE: begin
        if (tmr_expired) begin
          finish  = 1'b1;
          phase_n = PH_IDLE;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  // timer reload on every phase change, length chosen by the phase entered
  always_comb begin
    tmr_load = (phase_n != phase_q) || wr_load;
    unique case (phase_n)
      PH_WR_CS:   tmr_val = TMR_W'(CS_CYC - 1);
      PH_WR_HOLD: tmr_val = TMR_W'(DH_CYC - 1);
      PH_LD_GAP:  tmr_val = TMR_W'(LS_CYC - 1);
      PH_LD_LOW:  tmr_val = TMR_W'(LDW_CYC - 1);
      PH_LD_HOLD: tmr_val = TMR_W'(LH_CYC - 1);
      PH_CL_LOW:  tmr_val = TMR_W'(CLW_CYC - 1);
      PH_SETTLE:  tmr_val = TMR_W'(settle_len_q - 1'b1);
      default:    tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_IDLE;
      op_q         <= OP_WRITE;
      second_q     <= 1'b0;
      chan_q       <= 1'b0;
      code_a_q     <= '0;
      code_b_q     <= '0;
      mask_q       <= 2'b00;
      settle_q     <= 1'b0;
      settle_len_q <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      second_q <= second_n;
      done     <= finish;
      if (accept)      busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (accept) begin
        op_q         <= req_op;
        chan_q       <= req_chan;
        code_a_q     <= req_data;
        code_b_q     <= req_data_b;
        mask_q       <= (req_op == OP_DUAL) ? 2'b11 : req_mask;
        settle_q     <= settle_en && (settle_cycles != '0);
        settle_len_q <= settle_cycles;
      end
    end
  end
endmodule

// File: rtl/dacseq_busreg.sv
`timescale 1ns/1ps
module dacseq_busreg
  import dacseq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase_n,
  input  logic              wr_load,
  input  logic              wr_chan,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NCH-1:0]    mask,
  input  logic              half_load,
  input  logic              half_val,
  output logic              cs_n,
  output logic              chan,
  output logic [DATA_W-1:0] data,
  output logic [NCH-1:0]    load_n,
  output logic              clr_n,
  output logic              half
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n  <= 1'b1;
      chan  <= 1'b0;
      data  <= '0;
      clr_n <= 1'b1;
      half  <= 1'b0;
    end else begin
      cs_n  <= (phase_n != PH_WR_CS);
      clr_n <= (phase_n != PH_CL_LOW);
      if (wr_load) begin
        chan <= wr_chan;
        data <= wr_data;
      end
      if (half_load) half <= half_val;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) load_n[ch] <= 1'b1;
      else     load_n[ch] <= !((phase_n == PH_LD_LOW) && mask[ch]);
    end
  end
endmodule

// File: rtl/dacbus_seq.sv
`timescale 1ns/1ps
module dacbus_seq
  import dacseq_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int SETTLE_W  = 16,
  parameter int CLK_NS    = 10,
  parameter int T_CSW_NS  = 30,
  parameter int T_CHS_NS  = 30,
  parameter int T_DS_NS   = 30,
  parameter int T_DH_NS   = 10,
  parameter int T_LS_NS   = 20,
  parameter int T_LDW_NS  = 20,
  parameter int T_LH_NS   = 10,
  parameter int T_CLW_NS  = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic                req_chan,
  input  logic [DATA_W-1:0]   req_data,
  input  logic [DATA_W-1:0]   req_data_b,
  input  logic [1:0]          req_mask,
  input  logic                req_preset,
  input  logic                settle_en,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                busy,
  output logic                done,
  output logic                dac_cs_n,
  output logic                dac_chan,
  output logic [DATA_W-1:0]   dac_data,
  output logic                dac_load_a_n,
  output logic                dac_load_b_n,
  output logic                dac_clr_n,
  output logic                dac_half
);
  localparam int NCH     = 2;
  localparam int CS_CYC  = max3(ns_to_cyc(T_CSW_NS, CLK_NS),
                                ns_to_cyc(T_CHS_NS, CLK_NS),
                                ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int DH_CYC  = ns_to_cyc(T_DH_NS, CLK_NS);
  localparam int LS_CYC  = ns_to_cyc(T_LS_NS, CLK_NS);
  localparam int LDW_CYC = ns_to_cyc(T_LDW_NS, CLK_NS);
  localparam int LH_CYC  = ns_to_cyc(T_LH_NS, CLK_NS);
  localparam int CLW_CYC = ns_to_cyc(T_CLW_NS, CLK_NS);
  localparam int TMR_W   = (SETTLE_W > 8) ? SETTLE_W : 8;

  logic              tmr_load, tmr_expired;
  logic [TMR_W-1:0]  tmr_val;
  phase_e            phase_n;
  logic              wr_load, wr_chan, half_load, half_val;
  logic [DATA_W-1:0] wr_data;
  logic [NCH-1:0]    mask_q, load_n;

  dacseq_ctrl #(
    .DATA_W(DATA_W), .SETTLE_W(SETTLE_W), .TMR_W(TMR_W),
    .CS_CYC(CS_CYC), .DH_CYC(DH_CYC), .LS_CYC(LS_CYC),
    .LDW_CYC(LDW_CYC), .LH_CYC(LH_CYC), .CLW_CYC(CLW_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(op_e'(req_op)), .req_chan(req_chan),
    .req_data(req_data), .req_data_b(req_data_b), .req_mask(req_mask),
    .req_preset(req_preset), .settle_en(settle_en), .settle_cycles(settle_cycles),
    .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .phase_n(phase_n), .wr_load(wr_load), .wr_chan(wr_chan), .wr_data(wr_data),
    .mask_q(mask_q), .half_load(half_load), .half_val(half_val),
    .busy(busy), .done(done)
  );

  dacseq_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  dacseq_busreg #(.DATA_W(DATA_W), .NCH(NCH)) u_bus (
    .clk(clk), .rst(rst), .phase_n(phase_n),
    .wr_load(wr_load), .wr_chan(wr_chan), .wr_data(wr_data),
    .mask(mask_q), .half_load(half_load), .half_val(half_val),
    .cs_n(dac_cs_n), .chan(dac_chan), .data(dac_data),
    .load_n(load_n), .clr_n(dac_clr_n), .half(dac_half)
  );

  assign dac_load_a_n = load_n[0];
  assign dac_load_b_n = load_n[1];
endmodule

// File: rtl/dacbus_seq_chk.sv
`timescale 1ns/1ps
module dacbus_seq_chk
  import dacseq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CLK_NS   = 10,
  parameter int T_CSW_NS = 30,
  parameter int T_CHS_NS = 30,
  parameter int T_DS_NS  = 30,
  parameter int T_LDW_NS = 20,
  parameter int T_CLW_NS = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              cs_n,
  input logic              chan,
  input logic [DATA_W-1:0] data,
  input logic              ld_a_n,
  input logic              ld_b_n,
  input logic              clr_n,
  input logic              half
);
  localparam int CS_CYC  = max3(ns_to_cyc(T_CSW_NS, CLK_NS),
                                ns_to_cyc(T_CHS_NS, CLK_NS),
                                ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int LDW_CYC = ns_to_cyc(T_LDW_NS, CLK_NS);
  localparam int CLW_CYC = ns_to_cyc(T_CLW_NS, CLK_NS);

  logic [15:0] cs_lo, la_lo, lb_lo, cl_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_lo <= '0; la_lo <= '0; lb_lo <= '0; cl_lo <= '0;
    end else begin
      cs_lo <= cs_n   ? 16'd0 : cs_lo + 16'd1;
      la_lo <= ld_a_n ? 16'd0 : la_lo + 16'd1;
      lb_lo <= ld_b_n ? 16'd0 : lb_lo + 16'd1;
      cl_lo <= clr_n  ? 16'd0 : cl_lo + 16'd1;
    end
  end

  p_cs_width_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> cs_lo == 16'(CS_CYC));
  p_bus_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n)) |-> ($stable(data) && $stable(chan)));
  p_bus_hold_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> ($stable(data) && $stable(chan)));
  p_lda_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ld_a_n) |-> la_lo == 16'(LDW_CYC));
  p_ldb_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ld_b_n) |-> lb_lo == 16'(LDW_CYC));
  p_clr_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(clr_n) |-> cl_lo == 16'(CLW_CYC));
  p_half_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> $stable(half));
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_idle_high_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && ld_a_n && ld_b_n && clr_n));
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> (ld_a_n && ld_b_n && clr_n));
endmodule

bind dacbus_seq dacbus_seq_chk #(
  .DATA_W(DATA_W), .CLK_NS(CLK_NS), .T_CSW_NS(T_CSW_NS), .T_CHS_NS(T_CHS_NS),
  .T_DS_NS(T_DS_NS), .T_LDW_NS(T_LDW_NS), .T_CLW_NS(T_CLW_NS)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .cs_n(dac_cs_n),
  .chan(dac_chan), .data(dac_data), .ld_a_n(dac_load_a_n),
  .ld_b_n(dac_load_b_n), .clr_n(dac_clr_n), .half(dac_half)
);

// File: tb/dacbus_seq_test.sv
`timescale 1ns/1ps
module dacbus_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int SW = 16;
  localparam int NT = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic req_chan = 1'b0;
  logic [DW-1:0] req_data = '0, req_data_b = '0;
  logic [1:0] req_mask = 2'b00;
  logic req_preset = 1'b0;
  logic settle_en = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic busy, done, dac_cs_n, dac_chan, dac_load_a_n, dac_load_b_n, dac_clr_n, dac_half;
  logic [DW-1:0] dac_data;

  int n_chk = 0, n_fail = 0;
  int e_cs, e_dh, e_ls, e_ldw, e_lh, e_clw;

  logic tr_cs [0:NT-1], tr_la [0:NT-1], tr_lb [0:NT-1], tr_cl [0:NT-1];
  logic tr_half [0:NT-1], tr_chan [0:NT-1], tr_busy [0:NT-1], tr_done [0:NT-1];
  logic [DW-1:0] tr_data [0:NT-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  dacbus_seq #(.DATA_W(DW), .SETTLE_W(SW), .CLK_NS(CLK_PERIOD)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_chan(req_chan), .req_data(req_data), .req_data_b(req_data_b),
    .req_mask(req_mask), .req_preset(req_preset), .settle_en(settle_en),
    .settle_cycles(settle_cycles), .busy(busy), .done(done),
    .dac_cs_n(dac_cs_n), .dac_chan(dac_chan), .dac_data(dac_data),
    .dac_load_a_n(dac_load_a_n), .dac_load_b_n(dac_load_b_n),
    .dac_clr_n(dac_clr_n), .dac_half(dac_half)
  );

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic pick(input int sig, input int i);
    case (sig)
      0: return tr_cs[i];
      1: return tr_la[i];
      2: return tr_lb[i];
      default: return tr_cl[i];
    endcase
  endfunction

  function automatic int low_cnt(input int sig);
    int n = 0;
    for (int i = 0; i < NT; i++) if (pick(sig, i) == 1'b0) n++;
    return n;
  endfunction

  function automatic int first_low(input int sig);
    for (int i = 0; i < NT; i++) if (pick(sig, i) == 1'b0) return i;
    return -1;
  endfunction

  function automatic int done_at();
    for (int i = 0; i < NT; i++) if (tr_done[i]) return i;
    return -1;
  endfunction

  function automatic int done_cnt();
    int n = 0;
    for (int i = 0; i < NT; i++) if (tr_done[i]) n++;
    return n;
  endfunction

  // issue one command, then record NT cycles sampled at the falling edge;
  // inj_at >= 0 injects a write of channel B, code 0x0F0, at that sample
  task automatic run(input logic [1:0] op, input logic ch, input logic [DW-1:0] d,
                     input logic [DW-1:0] db, input logic [1:0] m, input logic pre,
                     input logic sen, input int scyc, input int inj_at);
    @(negedge clk);
    req_op = op; req_chan = ch; req_data = d; req_data_b = db; req_mask = m;
    req_preset = pre; settle_en = sen; settle_cycles = SW'(scyc);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (i > 0) @(negedge clk);
      tr_cs[i] = dac_cs_n; tr_la[i] = dac_load_a_n; tr_lb[i] = dac_load_b_n;
      tr_cl[i] = dac_clr_n; tr_half[i] = dac_half; tr_chan[i] = dac_chan;
      tr_data[i] = dac_data; tr_busy[i] = busy; tr_done[i] = done;
      if (i == inj_at) begin
        req_op = 2'd0; req_chan = 1'b1; req_data = 12'h0F0; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset_state();
    chk("R1", dac_cs_n, 1, "cs_n after reset");
    chk("R1", dac_load_a_n & dac_load_b_n, 1, "load strobes after reset");
    chk("R1", dac_clr_n, 1, "clr_n after reset");
    chk("R1", dac_half, 0, "half after reset");
    chk("R1", dac_data, 0, "data after reset");
    chk("R1", busy | done, 0, "busy/done after reset");
  endtask

  task automatic t_write(input logic ch, input logic [DW-1:0] code, input logic sen, input int scyc);
    int bad = 0, w, busy_n = 0;
    run(2'd0, ch, code, 12'h000, 2'b00, 1'b0, sen, scyc, -1);
    w = e_cs + e_dh;
    for (int i = 0; i < w; i++) if (tr_data[i] !== code || tr_chan[i] !== ch) bad++;
    for (int i = 0; i < NT; i++) if (tr_busy[i]) busy_n++;
    chk("R2", first_low(0), 0, "cs_n falls first cycle");
    chk("R9", low_cnt(0), e_cs, "cs_n low cycles");
    chk("R2", bad, 0, "cycles with wrong data/chan through hold");
    chk("R6", done_at(), w, "write done index (settle never applies)");
    chk("R7", busy_n, w, "busy cycles");
    chk("R7", done_cnt(), 1, "done pulses");
    chk("R8", low_cnt(1) + low_cnt(2) + low_cnt(3), 0, "other strobes during write");
  endtask

  task automatic t_load(input logic [1:0] m);
    int base;
    run(2'd1, 1'b0, 12'h000, 12'h000, m, 1'b0, 1'b0, 0, -1);
    base = e_ls;
    chk("R3", low_cnt(1), m[0] ? e_ldw : 0, "load A low cycles");
    chk("R3", low_cnt(2), m[1] ? e_ldw : 0, "load B low cycles");
    if (m[0]) chk("R3", first_low(1), base, "load A fall index");
    if (m[1]) chk("R3", first_low(2), base, "load B fall index");
    chk("R3", done_at(), e_ls + e_ldw + e_lh, "load done index");
    chk("R8", low_cnt(0), 0, "cs_n during load");
  endtask

  task automatic t_dual();
    int w, d, ov = 0;
    run(2'd3, 1'b1, 12'h3A5, 12'hC5A, 2'b00, 1'b0, 1'b0, 0, -1);
    w = e_cs + e_dh;
    d = 2 * w + e_ls;
    chk("R4", tr_data[0], 12'h3A5, "first write code");
    chk("R4", tr_chan[0], 0, "first write channel");
    chk("R4", tr_data[w], 12'hC5A, "second write code");
    chk("R4", tr_chan[w], 1, "second write channel");
    chk("R4", low_cnt(0), 2 * e_cs, "cs_n low cycles over both writes");
    chk("R4", first_low(1), d, "load A fall index");
    chk("R4", first_low(2), d, "load B fall index");
    chk("R4", low_cnt(1) * 100 + low_cnt(2), e_ldw * 101, "both strobe widths");
    chk("R4", done_at(), d + e_ldw + e_lh, "dual done index");
    for (int i = 0; i < NT; i++) if (!tr_cs[i] && (!tr_la[i] || !tr_lb[i] || !tr_cl[i])) ov++;
    chk("R8", ov, 0, "cs_n overlapping a strobe");
  endtask

  task automatic t_clear(input logic pre, input logic sen, input int scyc);
    int extra;
    extra = (sen && scyc != 0) ? scyc : 0;
    run(2'd2, 1'b0, 12'h000, 12'h000, 2'b00, pre, sen, scyc, -1);
    chk("R5", tr_half[0], pre, "half set before clear");
    chk("R5", tr_cl[0], 1, "clr_n still high in preset cycle");
    chk("R5", first_low(3), 1, "clr_n fall index");
    chk("R5", low_cnt(3), e_clw, "clr_n low cycles");
    chk("R6", done_at(), 1 + e_clw + extra, "clear done index");
    chk("R5", tr_half[NT-1], pre, "half retained after clear");
  endtask

  task automatic t_settle(input logic sen, input int scyc);
    int extra;
    extra = (sen && scyc != 0) ? scyc : 0;
    run(2'd1, 1'b0, 12'h000, 12'h000, 2'b01, 1'b0, sen, scyc, -1);
    chk("R6", done_at(), e_ls + e_ldw + e_lh + extra, "load done with settling");
    chk("R6", tr_busy[e_ls + e_ldw + e_lh + extra - 1], 1, "busy through settling");
  endtask

  task automatic t_busy_ignore();
    int bad = 0;
    run(2'd0, 1'b0, 12'h5A5, 12'h000, 2'b00, 1'b0, 1'b0, 0, 1);
    for (int i = 0; i < NT; i++) if (tr_data[i] !== 12'h5A5 || tr_chan[i] !== 1'b0) bad++;
    chk("R7", bad, 0, "bus changed by request while busy");
    chk("R7", low_cnt(0), e_cs, "cs_n low cycles with ignored request");
    chk("R7", done_cnt(), 1, "done pulses with ignored request");
  endtask

  initial begin
    e_cs  = cyc(30);
    e_dh  = cyc(10);
    e_ls  = cyc(20);
    e_ldw = cyc(20);
    e_lh  = cyc(10);
    e_clw = cyc(30);
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_write(1'b0, 12'hABC, 1'b0, 0);
    t_write(1'b1, 12'h123, 1'b1, 50);
    t_load(2'b01);
    t_load(2'b10);
    t_load(2'b11);
    t_load(2'b00);
    t_dual();
    t_clear(1'b1, 1'b0, 0);
    t_clear(1'b0, 1'b1, 0);
    t_clear(1'b1, 1'b1, 7);
    t_settle(1'b1, 20);
    t_settle(1'b0, 20);
    t_settle(1'b1, 0);
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule